// File: doc/BRIEF.md
# Serial EEPROM Responder (SPI Target)

This block answers an SPI controller as if it were a small byte-wide serial EEPROM. A system clock oversamples the serial clock, the data-in line and the active-low select. Whole bytes are assembled from these samples and passed to a command sequencer. The sequencer holds a write-enable latch, a busy timer and a byte array. It returns data or status on the data-out line. The block can stand in for a real memory when a controller design is tested, and it checks that controller's command order for itself.

Commands are one opcode byte. Memory access commands then take a three-byte address. A program command collects data bytes into a page buffer, and the array is only updated when the select line is released. After that update the device stays busy for a fixed number of system clocks. The serial pins carry all data. There is no parallel stream port, so no valid/ready or back-pressure rules apply at the edge. Each SPI byte is consumed internally in the cycle it completes.

Top module: `spi_eeprom_slave`

## Requirements
- R1: `spi_miso` is 1 while the select is inactive, during opcode and address bytes, and whenever no data or status is being returned.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Neither takes effect until the select is released, and only when the frame ends on a byte boundary.
- R3: Opcode 0x02 (program) is accepted only if the latch was already set when the frame began. A set command earlier in the same frame does not enable that program.
- R4: Opcodes 0x02 and 0x03 take three address bytes, most significant first. The array index is the low log2(DEPTH) bits of this 24-bit value.
- R5: Program data bytes go to consecutive addresses, wrapping at DEPTH, and are written when the select is released. At most PAGE_BYTES bytes are kept; later bytes are dropped. The latch clears when the write takes place.
- R6: A program frame that ends in a partial byte, or that has no data bytes, writes nothing, starts no busy period and leaves the latch set.
- R7: After a write the device is busy for WRITE_CYCLES system clocks. A frame whose opcode completes while busy is ignored as a whole, and `spi_miso` stays 1, so reads return 0xFF.
- R8: Opcode 0x03 (read) returns the byte at the address on the byte after the address. The address then increments for each further byte, wrapping from DEPTH-1 to 0.
- R9: Opcode 0x05 returns the status byte on every following byte: bit 0 is busy, bit 1 is the write-enable latch, and the other bits are 0.
- R10: Releasing the select in the middle of a byte aborts the frame. A partial opcode has no effect.
- R11: After reset the array holds 0x00, the latch is clear and the device is not busy.
- R12: The SPI mode is mode 0, MSB first. `spi_mosi` is sampled on the rising serial clock edge and `spi_miso` changes after the falling edge. Each serial clock phase must last at least 6 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_clk | input | 1 | Serial clock from the controller, idle low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to the controller; high when idle |

## Verification
On every cycle the assertions check the following:
- a write starts the busy timer, happens only while idle, and clears the latch;
- the buffer only fills while the latch is set;
- status is never served while busy;
- bytes only complete while selected;
- the line stays high when deselected;
- a release leaves the bit count on a byte boundary.

Only the bench's scenarios can show the rest. These are the deferred effect of the latch commands, a program ignored when the enable is in the same frame, partial and empty writes, and the drop of bytes past the page limit. They also include reads ignored during the busy window, address wrap and MSB-first address order. The bench shows these by comparing every returned byte with its own behavioural model.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_PROGRAM   = 8'h02;
  localparam logic [7:0] OP_FETCH     = 8'h03;
  localparam logic [7:0] OP_STATUS    = 8'h05;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_STATUS,
    ST_DISCARD
  } phase_t;
endpackage

// File: rtl/eep_spi_shifter.sv
module eep_spi_shifter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_in,
  input  logic       mosi_in,
  input  logic       csn_in,
  input  logic [7:0] tx_next,
  output logic       cs_release,
  output logic       on_boundary,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       miso
);
  localparam int SL = SYNC_STAGES - 1;

  logic [SL:0] sclk_s, mosi_s, csn_s;
  logic        csn_prev, sclk_prev;
  logic [2:0]  bit_cnt;
  logic [6:0]  rx_sr;
  logic [7:0]  tx_sr;
  logic        selected, cs_engage, sck_rise, sck_fall;

  // bring the serial pins into the system clock domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s    <= '0;
      mosi_s    <= '0;
      csn_s     <= '1;
      csn_prev  <= 1'b1;
      sclk_prev <= 1'b0;
    end else begin
      sclk_s    <= {sclk_s[SL-1:0], sclk_in};
      mosi_s    <= {mosi_s[SL-1:0], mosi_in};
      csn_s     <= {csn_s[SL-1:0], csn_in};
      csn_prev  <= csn_s[SL];
      sclk_prev <= sclk_s[SL];
    end
  end

  assign selected    = !csn_s[SL];
  assign cs_release  = csn_s[SL] && !csn_prev;
  assign cs_engage   = !csn_s[SL] && csn_prev;
  assign sck_rise    = selected && sclk_s[SL] && !sclk_prev;
  assign sck_fall    = selected && !sclk_s[SL] && sclk_prev;
  assign on_boundary = (bit_cnt == 3'd0);
  assign miso        = selected ? tx_sr[7] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= 3'd0;
      rx_sr      <= '0;
      tx_sr      <= 8'hFF;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (cs_release || cs_engage) begin
        bit_cnt <= 3'd0;
        rx_sr   <= '0;
        tx_sr   <= 8'hFF;
      end else begin
        if (sck_rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_s[SL]};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_valid <= 1'b1;
            byte_data  <= {rx_sr, mosi_s[SL]};
          end
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0) tx_sr <= tx_next;
          else                 tx_sr <= {tx_sr[6:0], 1'b1};
        end
      end
    end
  end

  assert_byte_while_selected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(selected));
  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |-> miso);
  assert_release_realigns_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_release |=> on_boundary);
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array #(
  parameter int DEPTH      = 256,
  parameter int PAGE_BYTES = 8,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [ADDR_W-1:0]            base,
  input  logic [CNT_W-1:0]             count,
  input  logic [PAGE_BYTES-1:0][7:0]   page,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [7:0]                   rd_data
);
  logic [7:0] mem [DEPTH];

  // a whole page lands in one clock, each byte at base plus its slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (CNT_W'(i) < count) mem[base + ADDR_W'(i)] <= page[i];
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 400,
  localparam int ADDR_W      = $clog2(DEPTH),
  localparam int CNT_W       = $clog2(PAGE_BYTES + 1),
  localparam int IDX_W       = $clog2(PAGE_BYTES),
  localparam int BUSY_W      = $clog2(WRITE_CYCLES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_release,
  input  logic                       on_boundary,
  input  logic                       byte_valid,
  input  logic [7:0]                 byte_data,
  input  logic [7:0]                 rd_data,
  output logic [7:0]                 tx_next,
  output logic                       commit,
  output logic [ADDR_W-1:0]          cur,
  output logic [CNT_W-1:0]           wcnt,
  output logic [PAGE_BYTES-1:0][7:0] wbuf
);
  phase_t          phase;
  logic [1:0]      addr_left;
  logic            is_prog;
  logic [15:0]     addr_hi;
  logic [23:0]     full_addr;
  logic            wel, want_set, want_clr, busy;
  logic [BUSY_W-1:0] busy_cnt;

  assign busy      = (busy_cnt != '0);
  assign full_addr = {addr_hi, byte_data};
  assign commit    = cs_release && (phase == ST_WDATA) && on_boundary && (wcnt != '0);

  always_comb begin
    unique case (phase)
      ST_RDATA:  tx_next = rd_data;
      ST_STATUS: tx_next = {6'b0, wel, busy};
      default:   tx_next = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= ST_OPCODE;
      addr_left <= 2'd0;
      is_prog   <= 1'b0;
      addr_hi   <= '0;
      cur       <= '0;
      wcnt      <= '0;
      wbuf      <= '0;
      wel       <= 1'b0;
      want_set  <= 1'b0;
      want_clr  <= 1'b0;
      busy_cnt  <= '0;
    end else begin
      if (commit)    busy_cnt <= BUSY_W'(WRITE_CYCLES);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (cs_release) begin
        phase    <= ST_OPCODE;
        want_set <= 1'b0;
        want_clr <= 1'b0;
        wcnt     <= '0;
        if (commit)                       wel <= 1'b0;
        else if (on_boundary && want_set) wel <= 1'b1;
        else if (on_boundary && want_clr) wel <= 1'b0;
      end else if (byte_valid) begin
        unique case (phase)
          ST_OPCODE: begin
            if (busy) phase <= ST_DISCARD;
            else begin
              unique case (byte_data)
                OP_LATCH_SET: begin want_set <= 1'b1; phase <= ST_DISCARD; end
                OP_LATCH_CLR: begin want_clr <= 1'b1; phase <= ST_DISCARD; end
                OP_PROGRAM: begin
                  is_prog   <= 1'b1;
                  addr_left <= 2'd2;
                  phase     <= wel ? ST_ADDR : ST_DISCARD;
                end
                OP_FETCH: begin
                  is_prog   <= 1'b0;
                  addr_left <= 2'd2;
                  phase     <= ST_ADDR;
                end
                OP_STATUS: phase <= ST_STATUS;
                default:   phase <= ST_DISCARD;
              endcase
            end
          end
          ST_ADDR: begin
            addr_hi   <= {addr_hi[7:0], byte_data};
            addr_left <= addr_left - 2'd1;
            if (addr_left == 2'd0) begin
              cur   <= full_addr[ADDR_W-1:0];
              phase <= is_prog ? ST_WDATA : ST_RDATA;
            end
          end
          ST_WDATA: begin
            if (wcnt != CNT_W'(PAGE_BYTES)) begin
              wbuf[wcnt[IDX_W-1:0]] <= byte_data;
              wcnt <= wcnt + 1'b1;
            end
          end
          ST_RDATA: cur <= cur + 1'b1;
          default: ;
        endcase
      end
    end
  end

  assert_commit_starts_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);
  assert_commit_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
  assert_commit_clears_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !wel);
  assert_fill_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_WDATA) |-> wel);
  assert_status_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_STATUS) |-> !busy);
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int DEPTH        = 256,
  parameter int PAGE_BYTES   = 8,
  parameter int WRITE_CYCLES = 400,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_clk,
  input  logic spi_mosi,
  input  logic spi_cs_n,
  output logic spi_miso
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1);

  logic                       cs_release, on_boundary, byte_valid, commit;
  logic [7:0]                 byte_data, tx_next, rd_data;
  logic [ADDR_W-1:0]          cur;
  logic [CNT_W-1:0]           wcnt;
  logic [PAGE_BYTES-1:0][7:0] wbuf;

  eep_spi_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_in(spi_clk), .mosi_in(spi_mosi), .csn_in(spi_cs_n),
    .tx_next(tx_next), .cs_release(cs_release), .on_boundary(on_boundary),
    .byte_valid(byte_valid), .byte_data(byte_data), .miso(spi_miso)
  );

  eep_cmd_ctrl #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_release(cs_release), .on_boundary(on_boundary),
    .byte_valid(byte_valid), .byte_data(byte_data), .rd_data(rd_data), .tx_next(tx_next),
    .commit(commit), .cur(cur), .wcnt(wcnt), .wbuf(wbuf)
  );

  eep_cell_array #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .base(cur), .count(wcnt),
    .page(wbuf), .rd_addr(cur), .rd_data(rd_data)
  );
endmodule

// File: tb/spi_eeprom_slave_tb_top.sv
module spi_eeprom_slave_tb_top;
  localparam int DEPTH = 256, PAGE = 8, WCYC = 400, HALF = 8;
  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  int   n_cmp = 0, n_bad = 0, idle_run = 0;
  bit   done = 1'b0;
  logic [7:0] ref_mem [DEPTH];
  bit   ref_wel = 1'b0, ref_busy = 1'b0;

  spi_eeprom_slave #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_clk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n), .spi_miso(miso)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // R1: line idles high once the select has been inactive for a while
  always @(negedge clk) begin
    if (!rst_n || !cs_n) idle_run <= 0;
    else begin
      idle_run <= idle_run + 1;
      if (idle_run >= 4) check("R1 idle", {7'b0, miso}, 8'h01);
    end
  end

  // behavioural model: expected returned bytes and state update for a frame
  task automatic model_frame(input bq_t tx, input int nbits, output bq_t exp);
    int full, part, a;
    full = nbits / 8;
    part = nbits % 8;
    exp = {};
    for (int k = 0; k < full; k++) exp.push_back(8'hFF);
    if (full == 0 || ref_busy) return;
    a = {tx[1], tx[2], tx[3]} % DEPTH;
    case (tx[0])
      8'h06: if (part == 0) ref_wel = 1'b1;
      8'h04: if (part == 0) ref_wel = 1'b0;
      8'h05: for (int k = 1; k < full; k++) exp[k] = {6'b0, ref_wel, 1'b0};
      8'h03: for (int k = 4; k < full; k++) exp[k] = ref_mem[(a + k - 4) % DEPTH];
      8'h02: if (ref_wel && full > 4 && part == 0) begin
        for (int k = 4; k < full; k++)
          if (k - 4 < PAGE) ref_mem[(a + k - 4) % DEPTH] = tx[k];
        ref_wel  = 1'b0;
        ref_busy = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic run(input string tag, input bq_t tx, input int nbits);
    bq_t exp, got;
    logic [7:0] sh;
    sh = 8'hFF;
    got = {};
    model_frame(tx, nbits, exp);
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = tx[b / 8][7 - (b % 8)];
      repeat (HALF) @(negedge clk);
      sh = {sh[6:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      if (b % 8 == 7) got.push_back(sh);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (4 * HALF) @(negedge clk);
    for (int k = 0; k < exp.size(); k++) check(tag, got[k], exp[k]);
  endtask

  task automatic frame(input string tag, input bq_t tx);
    run(tag, tx, 8 * tx.size());
  endtask

  task automatic wait_ready();
    repeat (WCYC + 60) @(negedge clk);
    ref_busy = 1'b0;
  endtask

  initial begin
    bq_t t;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 reset line", {7'b0, miso}, 8'h01);

    frame("R11 R9 status after reset", '{8'h05, 8'h00});
    frame("R11 R8 reset contents", '{8'h03, 8'h00, 8'h00, 8'h10, 8'h00, 8'h00});
    frame("R3 program without latch", '{8'h02, 8'h00, 8'h00, 8'h10, 8'hAA});
    frame("R3 readback", '{8'h03, 8'h00, 8'h00, 8'h10, 8'h00});
    frame("R3 enable and program in one frame", '{8'h06, 8'h02, 8'h00, 8'h00, 8'h10, 8'hBB});
    frame("R2 R3 readback", '{8'h03, 8'h00, 8'h00, 8'h10, 8'h00});
    frame("R2 latch set seen", '{8'h05, 8'h00, 8'h00});
    frame("R2 clear latch", '{8'h04});
    frame("R2 latch cleared", '{8'h05, 8'h00});

    // R4 R5 R12: upper address bits ignored, MSB-first address
    frame("R2 enable", '{8'h06});
    frame("R5 program", '{8'h02, 8'h12, 8'h34, 8'h56, 8'h11, 8'h22, 8'h33});
    frame("R7 read while busy", '{8'h03, 8'h00, 8'h00, 8'h56, 8'h00, 8'h00});
    wait_ready();
    frame("R5 latch cleared by write", '{8'h05, 8'h00});
    frame("R4 R8 R12 readback", '{8'h03, 8'h00, 8'h00, 8'h56, 8'h00, 8'h00, 8'h00});

    // R8 wrap at the array end
    frame("R2 enable", '{8'h06});
    frame("R5 wrap program", '{8'h02, 8'h00, 8'h00, 8'hFE, 8'hC1, 8'hC2, 8'hC3});
    wait_ready();
    frame("R8 wrap read", '{8'h03, 8'h00, 8'h00, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00});

    // R6 partial and empty program frames
    frame("R2 enable", '{8'h06});
    run("R6 partial data byte", '{8'h02, 8'h00, 8'h00, 8'h40, 8'h55, 8'hE0}, 43);
    frame("R6 no busy latch kept", '{8'h05, 8'h00});
    frame("R6 no data bytes", '{8'h02, 8'h00, 8'h00, 8'h40});
    frame("R6 still enabled", '{8'h05, 8'h00, 8'h00});
    frame("R6 location untouched", '{8'h03, 8'h00, 8'h00, 8'h40, 8'h00});

    // R7 status ignored while busy
    frame("R7 program", '{8'h02, 8'h00, 8'h00, 8'h41, 8'h77});
    frame("R7 status while busy", '{8'h05, 8'h00});
    wait_ready();
    frame("R7 after busy", '{8'h05, 8'h00});

    // R10 aborted opcode, R2 enable not on byte boundary
    run("R10 partial opcode", '{8'h06}, 4);
    frame("R10 latch unchanged", '{8'h05, 8'h00});
    run("R2 enable with trailing bits", '{8'h06, 8'hFF}, 11);
    frame("R2 latch unchanged", '{8'h05, 8'h00});

    // R5 bytes beyond the page are dropped
    frame("R2 enable", '{8'h06});
    t = '{8'h02, 8'h00, 8'h00, 8'h80};
    for (int i = 0; i < PAGE + 2; i++) t.push_back(8'hA0 + 8'(i));
    frame("R5 long program", t);
    wait_ready();
    t = '{8'h03, 8'h00, 8'h00, 8'h80};
    for (int i = 0; i < PAGE + 2; i++) t.push_back(8'h00);
    frame("R5 page limit readback", t);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule